// File: doc/BRIEF.md
# Pulse-Swallowing Rational Rate Divider

This block sits on a single-cycle enable strobe and thins it by a rational ratio. Out of every M+1 input strobes it forwards the first M and drops the last one, so the output rate is M/(M+1) of the input rate. A small state counter records how many strobes have been forwarded in the current cycle, and a decode of that counter against the selected count decides whether the next strobe is passed or dropped. After the dropped strobe the counter returns to its start state and a new cycle begins.

The count M comes from a 5-bit select input. It is taken in only while the counter is at its start state, so a cycle in progress always runs to its end with the count it began with. Everything is synchronous: the input is a clock-enable strobe, both outputs are registered, and no clock is gated.

Top module: `pulse_swallow_div`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `out_pulse` and `swallow_flag` are 0 and the counter is at the start of a cycle.
- R2: `out_pulse` is high for exactly one cycle, one clock after each forwarded `in_pulse`; with `in_pulse` low, `out_pulse` stays low.
- R3: In each cycle of M+1 input strobes, strobes 1 to M are forwarded and strobe M+1 is dropped (for M=6, six of every seven pass).
- R4: `swallow_flag` is high for exactly one cycle, one clock after a dropped strobe, and is never high together with `out_pulse`.
- R5: The strobe following a dropped strobe is strobe 1 of a new cycle and is forwarded.
- R6: `m_sel` is sampled only while no strobe has been forwarded since the last dropped strobe (or since reset); a change of `m_sel` in mid-cycle takes effect at the next cycle.
- R7: Values of `m_sel` below 4 act as 4.
- R8: With `m_sel`=31, 31 strobes of every 32 are forwarded.
- R9: Idle cycles between strobes do not change the count; only strobes advance the cycle position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_pulse | input | 1 | Input enable strobe, one cycle per event |
| m_sel | input | 5 | Forwarded strobes per cycle, M (4 to 31) |
| out_pulse | output | 1 | Registered forwarded strobe |
| swallow_flag | output | 1 | Registered one-cycle mark of a dropped strobe |

## Verification
The bench builds the block with its default 5-bit select and a floor of 4, which brings both ends of the count range within reach: the clamped floor through selects of 2 and 4, and the full ceiling of 31 forwarded strobes out of 32. Strobes are sent back to back and with idle gaps, and the select is changed in mid-cycle to show that the running cycle keeps its count.

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int M_W   = 5,
  parameter int M_MIN = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_pulse,
  input  logic [M_W-1:0] m_sel,
  output logic           out_pulse,
  output logic           swallow_flag
);

  localparam logic [M_W-1:0] MIN_V = M_W'(M_MIN);

  logic [M_W-1:0] cnt;
  logic [M_W-1:0] m_act;
  logic [M_W-1:0] m_req;
  logic [M_W-1:0] m_eff;
  logic           at_start;
  logic           at_end;

  assign m_req    = (m_sel < MIN_V) ? MIN_V : m_sel;
  assign at_start = (cnt == '0);
  assign m_eff    = at_start ? m_req : m_act;
  assign at_end   = (cnt == m_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt          <= '0;
      m_act        <= MIN_V;
      out_pulse    <= 1'b0;
      swallow_flag <= 1'b0;
    end else begin
      out_pulse    <= in_pulse & ~at_end;
      swallow_flag <= in_pulse & at_end;
      if (at_start) m_act <= m_req;
      if (in_pulse) cnt <= at_end ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pulse_swallow_div_chk.sv
module pulse_swallow_div_chk #(
  parameter int M_W   = 5,
  parameter int M_MIN = 4
) (
  input logic clk,
  input logic rst_n,
  input logic in_pulse,
  input logic out_pulse,
  input logic swallow_flag
);

  localparam int M_MAX = (1 << M_W) - 1;

  int pass_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pass_cnt <= 0;
    else if (swallow_flag) pass_cnt <= 0;
    else if (out_pulse) pass_cnt <= pass_cnt + 1;
  end

  p_out_needs_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pulse || swallow_flag) |-> $past(in_pulse));

  p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_pulse && swallow_flag));

  p_single_swallow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    swallow_flag |=> !swallow_flag);

  p_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    swallow_flag |-> pass_cnt >= M_MIN);

  p_ceiling_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_pulse |-> pass_cnt < M_MAX);

endmodule

bind pulse_swallow_div pulse_swallow_div_chk #(.M_W(M_W), .M_MIN(M_MIN)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .in_pulse(in_pulse),
  .out_pulse(out_pulse),
  .swallow_flag(swallow_flag)
);

// File: tb/sim_pulse_swallow_div.sv
module sim_pulse_swallow_div;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_pulse;
  logic [4:0] m_sel;
  logic       out_pulse;
  logic       swallow_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_swallow_div u0 (
    .clk(clk), .rst_n(rst_n), .in_pulse(in_pulse), .m_sel(m_sel),
    .out_pulse(out_pulse), .swallow_flag(swallow_flag)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  int    win_out, win_sw;

  // behavioural reference: forwarded count in cycle and the count in force
  bit exp_out, exp_sw;
  int ref_pos, ref_m;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_out = 1'b0; exp_sw = 1'b0; ref_pos = 0; ref_m = 4;
    end else begin
      if (ref_pos == 0) ref_m = (int'(m_sel) < 4) ? 4 : int'(m_sel);
      exp_out = 1'b0; exp_sw = 1'b0;
      if (in_pulse) begin
        if (ref_pos == ref_m) begin exp_sw = 1'b1; ref_pos = 0; end
        else begin exp_out = 1'b1; ref_pos = ref_pos + 1; end
      end
    end
  end

  task automatic check_int(input int act, input int exp, input string req, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit p);
    @(negedge clk);
    check_int(int'(out_pulse), int'(exp_out), cur_req, "out_pulse");
    check_int(int'(swallow_flag), int'(exp_sw), cur_req, "swallow_flag");
    win_out += int'(out_pulse);
    win_sw  += int'(swallow_flag);
    in_pulse = p;
  endtask

  task automatic burst(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step(1'b1);
      for (int g = 0; g < gap; g++) step(1'b0);
    end
  endtask

  task automatic window_end(input int eo, input int es);
    step(1'b0); step(1'b0);
    check_int(win_out, eo, cur_req, "forwarded count");
    check_int(win_sw, es, cur_req, "dropped count");
    win_out = 0; win_sw = 0;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_pulse = 1'b0; m_sel = 5'd6;
    win_out = 0; win_sw = 0;
    #(CLK_PERIOD*2 + 3);
    cur_req = "R1";
    check_int(int'(out_pulse), 0, "R1", "out_pulse in reset");
    check_int(int'(swallow_flag), 0, "R1", "swallow_flag in reset");
    @(negedge clk); rst_n = 1'b1;
    step(1'b0);

    cur_req = "R2";
    for (int i = 0; i < 20; i++) step(1'b0);
    window_end(0, 0);

    cur_req = "R3";
    burst(14, 0);
    window_end(12, 2);

    cur_req = "R5";
    burst(1, 0);
    window_end(1, 0);
    burst(6, 0);
    window_end(5, 1);

    cur_req = "R9";
    m_sel = 5'd4;
    burst(10, 2);
    window_end(8, 2);

    cur_req = "R7";
    m_sel = 5'd2;
    burst(10, 0);
    window_end(8, 2);
    m_sel = 5'd0;
    burst(5, 1);
    window_end(4, 1);

    cur_req = "R8";
    m_sel = 5'd31;
    burst(64, 0);
    window_end(62, 2);

    cur_req = "R6";
    m_sel = 5'd5;
    burst(3, 0);
    m_sel = 5'd10;
    burst(3, 0);
    window_end(5, 1);
    burst(11, 1);
    window_end(10, 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule